// File: doc/BRIEF.md
# CAN Error-State Status Encoder

This block sits next to the error counters of a CAN controller. Each clock it samples the transmit and receive error counts. It grades each count into a two-bit bus-status code: OK, warning, error-passive or bus-off. A new grade is accepted only after it has been seen on two successive samples. Bus-off can come only from the transmit counter. While the transmitter is bus-off, the receiver code shows bus-off as well. When the transmitter recovers, the receiver code drops straight to OK.

An eight-bit interrupt-enable register decides which code changes set the sticky status-change flag. The flag raises the interrupt request only when its own enable bit is set. The register is cleared and held at zero while the controller is in initialization mode. The status codes keep tracking the counters in that mode.

Top module: `can_err_state_enc`

## Requirements
- R1: `tx_state` grades the transmit count as 00 for 0..96, 01 for 97..128, 10 for 129..255 and 11 (bus-off) for 256 or more.
- R2: `rx_state` grades the receive count with the same limits, except that any count of 129 or more gives 10. It reads 11 only while `tx_state` is 11.
- R3: On the update in which `tx_state` leaves 11, `rx_state` becomes 00, whatever the receive count is. It follows the receive count again from the next accepted sample.
- R4: A new pair of grades is accepted only if the same pair was seen on two successive clock samples. The codes then change on the second of those edges. A value present for a single sample leaves the codes unchanged.
- R5: `chg_flag` is set on the same edge as the code update that sets it, and only on an update that a status enable qualifies.
- R6: `ien_q[3:2]` (transmitter) and `ien_q[5:4]` (receiver) are status enables with these codes. 00 means no change qualifies. 01 means only changes that enter or leave bus-off qualify (transmitter), or changes that enter or leave the 10/11 range (receiver). 10 means changes whose new code is not 00 qualify. 11 means every change qualifies.
- R7: A one-cycle pulse on `flag_clr` clears `chg_flag`. If the flag is set in the same cycle as the clear, the set wins.
- R8: `irq` is high exactly while `chg_flag` is 1 and `ien_q[6]` is 1.
- R9: `ien_q` resets to 0x00. It is forced to 0x00 while `init_req` and `init_ack` are both 1. `reg_wr` loads `reg_wdata` only when both are 0. The bit layout is 7 wake-up enable, 6 status-change enable, 5:4 receiver status enable, 3:2 transmitter status enable, 1 overrun enable, 0 receive-full enable.
- R10: `tx_state` and `rx_state` keep following the counters during initialization mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err_cnt | input | CNT_W | Transmit error count |
| rx_err_cnt | input | CNT_W | Receive error count |
| init_req | input | 1 | Initialization request |
| init_ack | input | 1 | Initialization acknowledge |
| reg_wr | input | 1 | Write strobe for the enable register |
| reg_wdata | input | 8 | Write data for the enable register |
| flag_clr | input | 1 | Clear strobe for the status-change flag |
| tx_state | output | 2 | Transmitter bus-status code |
| rx_state | output | 2 | Receiver bus-status code |
| chg_flag | output | 1 | Sticky status-change flag |
| irq | output | 1 | Status-change interrupt request |
| ien_q | output | 8 | Interrupt-enable register |

## Verification
Two events can fall in the same cycle: a qualified code update that sets the flag, and a clear strobe. The bench clears the flag first. It then moves the receive count across the passive boundary and pulses `flag_clr` in the cycle before the second sample, so the clear lands on the same edge as the update. The flag must read 1 afterwards. A second test puts a code update in the same edge as the end of the bus-off state, and checks that the receiver code is forced to OK there rather than graded from its counter.

// File: rtl/can_err_state_enc.sv
module can_err_state_enc #(
  parameter int CNT_W    = 9,
  parameter int WARN_LIM = 96,
  parameter int PASV_LIM = 128,
  parameter int OFF_LIM  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic             init_req,
  input  logic             init_ack,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  input  logic             flag_clr,
  output logic [1:0]       tx_state,
  output logic [1:0]       rx_state,
  output logic             chg_flag,
  output logic             irq,
  output logic [7:0]       ien_q
);
  localparam logic [CNT_W:0] WARN_L = (CNT_W+1)'(WARN_LIM);
  localparam logic [CNT_W:0] PASV_L = (CNT_W+1)'(PASV_LIM);
  localparam logic [CNT_W:0] OFF_L  = (CNT_W+1)'(OFF_LIM);

  function automatic logic [1:0] grade(input logic [CNT_W-1:0] c, input logic may_off);
    logic [CNT_W:0] v;
    v = {1'b0, c};
    if (may_off && v >= OFF_L) return 2'b11;
    else if (v > PASV_L)       return 2'b10;
    else if (v > WARN_L)       return 2'b01;
    else                       return 2'b00;
  endfunction

  function automatic logic qual(input logic [1:0] sel, input logic [1:0] o,
                                input logic [1:0] n, input logic is_tx);
    if (o == n) return 1'b0;
    case (sel)
      2'b01:   return is_tx ? ((o == 2'b11) != (n == 2'b11)) : (o[1] != n[1]);
      2'b10:   return n != 2'b00;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  logic [1:0] tx_raw, rx_raw, rx_nxt;
  logic [3:0] cand_q;
  logic       upd, hit, in_init, wr_ok;

  assign tx_raw  = grade(tx_err_cnt, 1'b1);
  assign rx_raw  = (tx_raw == 2'b11) ? 2'b11 : grade(rx_err_cnt, 1'b0);
  assign upd     = ({tx_raw, rx_raw} == cand_q) && ({tx_raw, rx_raw} != {tx_state, rx_state});
  assign rx_nxt  = (tx_state == 2'b11 && tx_raw != 2'b11) ? 2'b00 : rx_raw;
  assign hit     = upd && (qual(ien_q[3:2], tx_state, tx_raw, 1'b1) ||
                           qual(ien_q[5:4], rx_state, rx_nxt, 1'b0));
  assign in_init = init_req && init_ack;
  assign wr_ok   = !init_req && !init_ack && reg_wr;
  assign irq     = chg_flag && ien_q[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q   <= '0;
      tx_state <= 2'b00;
      rx_state <= 2'b00;
    end else begin
      cand_q <= {tx_raw, rx_raw};
      if (upd) begin
        tx_state <= tx_raw;
        rx_state <= rx_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chg_flag <= 1'b0;
    else if (hit)      chg_flag <= 1'b1;
    else if (flag_clr) chg_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ien_q <= 8'h00;
    else if (in_init) ien_q <= 8'h00;
    else if (wr_ok)   ien_q <= reg_wdata;
  end

  p_rx_off_only_with_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_state != 2'b11) |-> (rx_state != 2'b11));

  p_exit_off_rx_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_state) == 2'b11 && tx_state != 2'b11) |-> (rx_state == 2'b00));

  p_update_needs_two_samples_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_state != $past(tx_state)) |-> (grade($past(tx_err_cnt), 1'b1) == tx_state));

  p_flag_only_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_flag) |-> (tx_state != $past(tx_state) || rx_state != $past(rx_state)));

  p_clear_unless_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!chg_flag || tx_state != $past(tx_state) || rx_state != $past(rx_state)));

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q[6] |-> !irq);

  p_init_holds_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && init_ack) |=> (ien_q == 8'h00));

  p_no_write_outside_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req || init_ack) |=> (ien_q == $past(ien_q) || ien_q == 8'h00));
endmodule

// File: tb/can_err_state_enc_tb.sv
module can_err_state_enc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] tx_cnt = '0, rx_cnt = '0;
  logic init_req = 1'b0, init_ack = 1'b0, reg_wr = 1'b0, flag_clr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [1:0] tx_state, rx_state;
  logic chg_flag, irq;
  logic [7:0] ien_q;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_err_state_enc #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_cnt), .rx_err_cnt(rx_cnt),
    .init_req(init_req), .init_ack(init_ack), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .flag_clr(flag_clr), .tx_state(tx_state), .rx_state(rx_state),
    .chg_flag(chg_flag), .irq(irq), .ien_q(ien_q));

  // {tx count, rx count, expected tx code, expected rx code}
  localparam logic [21:0] VEC [10] = '{
    {9'd0,   9'd0,   2'b00, 2'b00},
    {9'd96,  9'd96,  2'b00, 2'b00},
    {9'd97,  9'd97,  2'b01, 2'b01},
    {9'd128, 9'd128, 2'b01, 2'b01},
    {9'd129, 9'd129, 2'b10, 2'b10},
    {9'd255, 9'd300, 2'b10, 2'b10},
    {9'd40,  9'd200, 2'b00, 2'b10},
    {9'd256, 9'd0,   2'b11, 2'b11},
    {9'd0,   9'd0,   2'b00, 2'b00},
    {9'd500, 9'd50,  2'b11, 2'b11}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply(input int t, input int r);
    tx_cnt = CW'(t);
    rx_cnt = CW'(r);
    step(); step(); step();
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic clr();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R9 reset ien", ien_q, 8'h00);
    check("R1 reset tx", {6'd0, tx_state}, 8'h00);
    check("R5 reset flag", {7'd0, chg_flag}, 8'h00);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < 10; i++) begin
      apply(int'(VEC[i][21:13]), int'(VEC[i][12:4]));
      check($sformatf("R1 vec%0d tx", i), {6'd0, tx_state}, {6'd0, VEC[i][3:2]});
      check($sformatf("R2 vec%0d rx", i), {6'd0, rx_state}, {6'd0, VEC[i][1:0]});
    end
    apply(0, 0);
    check("R5 no enable no flag", {7'd0, chg_flag}, 8'h00);

    // R4 one-sample glitch ignored, two samples accepted
    tx_cnt = 9'd200; step();
    tx_cnt = 9'd0;   step(); step();
    check("R4 glitch ignored", {6'd0, tx_state}, 8'h00);
    tx_cnt = 9'd200; step();
    check("R4 not yet after one edge", {6'd0, tx_state}, 8'h00);
    step();
    check("R4 taken after second edge", {6'd0, tx_state}, 8'h02);
    apply(0, 0);

    // R3 leaving bus-off forces rx OK
    apply(300, 150);
    check("R2 rx copies bus-off", {6'd0, rx_state}, 8'h03);
    tx_cnt = 9'd0; step(); step();
    check("R3 tx left bus-off", {6'd0, tx_state}, 8'h00);
    check("R3 rx forced ok", {6'd0, rx_state}, 8'h00);
    step();
    check("R3 rx follows counter next", {6'd0, rx_state}, 8'h02);
    apply(0, 0);

    // R6 classes
    wr(8'h40);
    apply(100, 0);
    check("R6 tx sel00 no flag", {7'd0, chg_flag}, 8'h00);
    wr(8'h4C);
    apply(200, 0);
    check("R5 tx sel11 flag", {7'd0, chg_flag}, 8'h01);
    check("R8 irq with enable", {7'd0, irq}, 8'h01);
    clr();
    check("R7 clear", {7'd0, chg_flag}, 8'h00);
    wr(8'h44);
    apply(110, 0);
    check("R6 tx sel01 ignores 10->01", {7'd0, chg_flag}, 8'h00);
    apply(300, 0);
    check("R6 tx sel01 enter bus-off", {7'd0, chg_flag}, 8'h01);
    clr();
    apply(0, 0);
    check("R6 tx sel01 leave bus-off", {7'd0, chg_flag}, 8'h01);
    clr();
    wr(8'h60);
    apply(0, 100);
    check("R6 rx sel10 to warning", {7'd0, chg_flag}, 8'h01);
    clr();
    apply(0, 0);
    check("R6 rx sel10 back to ok ignored", {7'd0, chg_flag}, 8'h00);
    wr(8'h50);
    apply(0, 110);
    check("R6 rx sel01 00->01 ignored", {7'd0, chg_flag}, 8'h00);
    apply(0, 200);
    check("R6 rx sel01 into passive", {7'd0, chg_flag}, 8'h01);
    clr();

    // R7 set and clear on the same edge
    rx_cnt = 9'd0; step();
    flag_clr = 1'b1; step();
    flag_clr = 1'b0;
    check("R7 set wins over clear", {7'd0, chg_flag}, 8'h01);
    check("R5 code updated with flag", {6'd0, rx_state}, 8'h00);
    clr();

    // R8 gating
    wr(8'h0C);
    apply(100, 0);
    check("R8 flag set", {7'd0, chg_flag}, 8'h01);
    check("R8 irq gated off", {7'd0, irq}, 8'h00);
    clr();
    apply(0, 0);

    // R9 / R10 initialization mode
    wr(8'hA5);
    check("R9 write run mode", ien_q, 8'hA5);
    init_req = 1'b1;
    wr(8'h3C);
    check("R9 write ignored req only", ien_q, 8'hA5);
    init_ack = 1'b1; step();
    check("R9 held zero in init", ien_q, 8'h00);
    wr(8'hFF);
    check("R9 write ignored in init", ien_q, 8'h00);
    apply(200, 0);
    check("R10 tx tracks in init", {6'd0, tx_state}, 8'h02);
    init_req = 1'b0; step();
    init_ack = 1'b0; step();
    wr(8'h81);
    check("R9 write after init", ien_q, 8'h81);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule